// File: doc/BRIEF.md
# Iterative 32x32 Integer Multiplier with Selectable Signedness

This block computes the 64-bit product of two 32-bit operands and returns one 32-bit half of it. It serves the multiply side of a small RV32 core: the low product, and the high product under signed-by-signed, signed-by-unsigned and unsigned-by-unsigned operand treatment. The signedness of each operand is set by its own control bit. The product is built one shift-add step per clock, so it needs a single 66-bit adder rather than a full array.

The core raises `start` for one cycle with the operands, the half select and the signedness control. The block reports `busy` while it works. It then pulses `done` for one cycle with the result registered on `result`. That value holds until the next operation finishes. A `start` that arrives while an operation runs is dropped.

Top module: `mext_mul`

## Requirements
- R1: With `op_code` other than 4'b1011 (the low-half code is 4'b1010), `result` is bits 31:0 of the 64-bit product.
- R2: With `op_code` = 4'b1011, `result` is bits 63:32 of the 64-bit product.
- R3: `sgn_ctl[0]` set makes `opa` signed (two's complement) and `sgn_ctl[1]` set makes `opb` signed; a clear bit makes that operand unsigned. So 2'b11 is signed by signed, 2'b01 is signed `opa` by unsigned `opb`, 2'b00 is unsigned by unsigned, and 2'b10 is unsigned `opa` by signed `opb`.
- R4: A `start` sampled while idle raises `busy` at the next edge. Exactly 33 clock edges after the accepting edge, `busy` falls while `done` and `result` become valid.
- R5: `busy` and `done` are never high in the same cycle.
- R6: `done` is high for exactly one cycle per operation.
- R7: `result` changes only in a cycle where `done` is high. It stays constant while the operands and controls change without a new operation.
- R8: A `start` sampled while `busy` is high has no effect: the running operation keeps its operands, its latency and its result.
- R9: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current operands and controls |
| op_code | input | 4 | 4'b1011 selects the high half; other values select the low half |
| sgn_ctl | input | 2 | Bit 0: `opa` signed; bit 1: `opb` signed |
| opa | input | 32 | First operand (multiplicand) |
| opb | input | 32 | Second operand (multiplier) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 32 | Selected half of the product |

## Verification
Several properties are checked on every cycle: `busy` and `done` are never high together, `done` lasts one cycle, `result` moves only with `done`, an idle `start` raises `busy`, and every run lasts exactly 33 busy cycles. The last check also catches a restart by a `start` that arrives mid-run. Whether the returned half is arithmetically correct can only be shown by the bench's scenarios. These compare each result with a 64-bit reference product across all four signedness codes and both halves, using the extreme operands and random ones. The bench also shows that a `start` raised mid-run leaves the first operation's result intact.

// File: rtl/mext_mul.sv
module mext_mul #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op_code,
  input  logic [1:0]      sgn_ctl,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int EW = XLEN + 1;
  localparam int AW = 2 * EW;
  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(EW + 1);
  localparam logic [3:0] OP_HIGH = 4'b1011;

  logic [AW-1:0] acc, mcand, acc_nx;
  logic [EW-1:0] mplier;
  logic [CW-1:0] step;
  logic          hi_sel, last;

  wire [EW-1:0] a_ext = {sgn_ctl[0] & opa[XLEN-1], opa};
  wire [EW-1:0] b_ext = {sgn_ctl[1] & opb[XLEN-1], opb};

  assign last   = (step == CW'(XLEN));
  assign acc_nx = !mplier[0] ? acc : (last ? acc - mcand : acc + mcand);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      step   <= '0;
      hi_sel <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc    <= acc_nx;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        step   <= step + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= hi_sel ? acc_nx[PW-1:XLEN] : acc_nx[XLEN-1:0];
        end
      end else if (start) begin
        busy   <= 1'b1;
        acc    <= '0;
        mcand  <= {{(AW-EW){a_ext[EW-1]}}, a_ext};
        mplier <= b_ext;
        step   <= '0;
        hi_sel <= (op_code == OP_HIGH);
      end
    end
  end

  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R4
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R4 R8
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == CW'(EW)));

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

// File: tb/mext_mul_bench.sv
`timescale 1ns/1ps
module mext_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = 4'b1010;
  logic [1:0]  sgn_ctl = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [31:0] result;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  mext_mul u_mext_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .sgn_ctl(sgn_ctl), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] ref_mul(input logic [31:0] a, b,
                                           input logic [1:0] sg, input logic [3:0] op);
    logic [63:0] ea, eb, p;
    ea = sg[0] ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sg[1] ? {{32{b[31]}}, b} : {32'b0, b};
    p  = ea * eb;
    return (op == 4'b1011) ? p[63:32] : p[31:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, b, input logic [1:0] sg,
                     input logic [3:0] op, input bit mid_start);
    int n;
    logic [31:0] exp;
    exp = ref_mul(a, b, sg, op);
    @(negedge clk);
    opa = a; opb = b; sgn_ctl = sg; op_code = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after start", busy, 1);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (mid_start && n == 5) begin
        opa = ~a; opb = b + 32'd7; op_code = ~op; sgn_ctl = ~sg; start = 1'b1;
      end else start = 1'b0;
      if (!done) chk("R4 busy held", busy, 1);
    end
    chk(mid_start ? "R8 latency with ignored start" : "R4 latency", n, 33);
    chk("R5 busy low at done", busy, 0);
    chk($sformatf("%s R3 mode=%b a=%h b=%h%s", (op == 4'b1011) ? "R2" : "R1",
                  sg, a, b, mid_start ? " R8" : ""), result, exp);
    opa = ~opa; opb = opb ^ 32'h5a5a_5a5a;
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R7 result held", result, exp);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] corner [5];
    logic [31:0] last_res;
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    chk("R9 busy reset", busy, 0);
    chk("R9 done reset", done, 0);
    chk("R9 result reset", result, 0);
    rst_n = 1'b1;

    run(32'd3, 32'd5, 2'b00, 4'b1010, 0);
    run(32'hFFFF_FFFD, 32'd5, 2'b11, 4'b1011, 0);
    run(32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 4'b0000, 0);
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int m = 0; m < 4; m++)
          for (int h = 0; h < 2; h++)
            run(corner[i], corner[j], 2'(m), h ? 4'b1011 : 4'b1010, 0);
    run(32'h8000_0000, 32'hFFFF_FFFF, 2'b11, 4'b1011, 1);
    run(32'hDEAD_BEEF, 32'h0BAD_F00D, 2'b01, 4'b1010, 1);
    for (int k = 0; k < 60; k++)
      run($urandom, $urandom, 2'($urandom), ($urandom % 2) ? 4'b1011 : 4'b1010, 0);

    last_res = result;
    opa = 32'h1111_2222; opb = 32'h3333_4444; op_code = 4'b1011;
    repeat (6) @(negedge clk);
    chk("R7 idle inputs change", result, last_res);
    chk("R6 no done while idle", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule